// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a CPU bus that issues byte, halfword and word accesses and a peripheral register file whose registers each have their own native width. A per-slot width table, one 2-bit code per 4-byte slot, tells the adapter the native width of every register. The adapter then turns each bus access into one or more backend accesses, each of exactly the register's native width.

A bus access narrower than its register becomes a lane extraction on reads, or a read-modify-write on writes. A bus access wider than its register is split into consecutive native accesses in big-endian order, so the lowest address carries the most significant part. Accesses outside the decoded window, to empty slots, with the reserved size code, or at misaligned addresses complete with an error and cause no backend traffic.

A small sequencer with four states (`ST_IDLE`, `ST_XFER`, `ST_WBACK`, `ST_DONE`) drives one backend access per cycle. Its transitions are:
- accept: `ST_IDLE` to `ST_XFER` on a valid, legal request.
- reject: `ST_IDLE` to `ST_DONE` on an illegal request.
- step: `ST_XFER` to `ST_XFER` while split pieces remain.
- merge: `ST_XFER` to `ST_WBACK` after the read of a read-modify-write.
- finish: `ST_XFER` to `ST_DONE` after the last piece.
- writeback: `ST_WBACK` to `ST_DONE`.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `rwa_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the register offset. Higher address bits have no effect on decoding or data.
- R2: A request is illegal if its offset is 0x200 or above, its slot code is 0, `req_size` is 3, or its address is not a multiple of its size. An illegal request gets `rsp_err`=1 and `rsp_rdata`=0 with `req_ready`, and causes no backend access. Legal requests return `rsp_err`=0.
- R3: When the access size equals the native width, exactly one backend access is made, at the request offset with the same size and data.
- R4: A read narrower than its register makes one backend read of the native width at the native-aligned address. The result is the addressed lane, taken big-endian: byte 0 of a register is its most significant byte. The result is right-aligned and zero-extended in `rsp_rdata`.
- R5: A write narrower than its register makes a backend read and then, in the next cycle, a backend write of the native width to the same address. The write changes only the addressed lane and keeps the other lanes.
- R6: A read or write wider than its register is split into (access bytes / native bytes) native accesses at ascending addresses. The lowest address carries the most significant part of the data.
- R7: Every backend access has `be_size` equal to its slot's native width, uses an address aligned to that width and below 0x200, and at most one is issued per cycle.
- R8: `req_ready` is a one-cycle pulse, given exactly once per request. It arrives n+1 cycles after the request is accepted, where n is the number of backend accesses. After reset `req_ready` and `be_valid` are low.
- R9: Size and width codes are log2 of the byte count (0 byte, 1 halfword, 2 word). Slot codes are 0 empty, 1 byte, 2 halfword and 3 word, at bits 2s+1:2s of `MAP` for slot s = offset bits 8:2. The default map is:
  - byte for offsets 0x000-0x03F and 0x100-0x1FF
  - halfword for 0x040-0x07F
  - word for 0x080-0x0BF
  - empty for 0x0C0-0x0FF

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (log2 bytes) |
| req_addr | input | BUS_AW | Bus byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read data, right-aligned, valid with `req_ready` |
| rsp_err | output | 1 | Error response, valid with `req_ready` |
| be_valid | output | 1 | Backend access this cycle |
| be_write | output | 1 | Backend access is a write |
| be_size | output | 2 | Backend size code (native width) |
| be_addr | output | 10 | Backend register offset |
| be_wdata | output | 32 | Backend write data, right-aligned |
| be_rdata | input | 32 | Backend read data, right-aligned, same cycle |

## Verification
In a narrow write, two functions meet in the write-back cycle: the old register value captured from the backend read, and the new lane taken from the bus data, are merged and written together. The bench provokes this with random byte and halfword writes to wider registers at random lanes, mixed with wide reads of the same registers. Correctness is judged by comparing every lane of each later read against a byte-level shadow model, and by counting the backend accesses of each request.

// File: rtl/rwa_pkg.sv
package rwa_pkg;

    localparam int OFF_W     = 10;
    localparam int DW        = 32;
    localparam int DEF_SLOTS = 128;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } seq_st_t;

    // Slot code: 0 empty, 1 byte, 2 halfword, 3 word
    function automatic logic [1:0] default_code(input int slot);
        if (slot < 16)      return 2'd1;
        else if (slot < 32) return 2'd2;
        else if (slot < 48) return 2'd3;
        else if (slot < 64) return 2'd0;
        else                return 2'd1;
    endfunction

    function automatic logic [2*DEF_SLOTS-1:0] default_map();
        logic [2*DEF_SLOTS-1:0] m;
        m = '0;
        for (int s = 0; s < DEF_SLOTS; s++) begin
            m[2*s +: 2] = default_code(s);
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/rwa_classify.sv
module rwa_classify
    import rwa_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int LIMIT  = 512,
    parameter int NSLOT  = 128,
    parameter logic [2*NSLOT-1:0] MAP = '0
) (
    input  logic [BUS_AW-1:0] addr,
    input  logic [1:0]        size,
    output logic              bad,
    output logic [1:0]        nlog,
    output logic [OFF_W-1:0]  off
);
    localparam int SLOT_W = $clog2(NSLOT);

    logic [SLOT_W-1:0] slot;
    logic [1:0]        code;
    logic              range_bad;
    logic              misal;

    always_comb begin
        off       = addr[OFF_W-1:0];
        slot      = off[SLOT_W+1:2];
        code      = MAP[{slot, 1'b0} +: 2];
        range_bad = ({{(32-OFF_W){1'b0}}, off} >= 32'(LIMIT));
        case (size)
            2'd1:    misal = off[0];
            2'd2:    misal = |off[1:0];
            default: misal = 1'b0;
        endcase
        nlog = code - 2'd1;
        bad  = range_bad | (code == 2'd0) | (size == 2'd3) | misal;
    end

endmodule

// File: rtl/rwa_seq.sv
module rwa_seq
    import rwa_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    bad,
    input  logic    rmw,
    input  logic [1:0] last,
    output seq_st_t st,
    output logic [1:0] idx,
    output logic    be_go,
    output logic    wback,
    output logic    done
);
    seq_st_t nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (req_valid) nxt = bad ? ST_DONE : ST_XFER;
            ST_XFER:  if (idx == last) nxt = rmw ? ST_WBACK : ST_DONE;
            ST_WBACK: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= 2'd0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE)                     idx <= 2'd0;
            else if (st == ST_XFER && idx != last) idx <= idx + 2'd1;
        end
    end

    always_comb begin
        be_go = 1'b0;
        wback = 1'b0;
        done  = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_XFER:  be_go = 1'b1;
            ST_WBACK: begin be_go = 1'b1; wback = 1'b1; end
            ST_DONE:  done = 1'b1;
        endcase
    end

endmodule

// File: rtl/rwa_lanes.sv
module rwa_lanes
    import rwa_pkg::*;
(
    input  logic [1:0]    alog,
    input  logic [1:0]    nlog,
    input  logic [1:0]    koff,
    input  logic [1:0]    idx,
    input  logic [1:0]    last,
    input  logic          split,
    input  logic          wback,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] be_rdata,
    output logic [DW-1:0] acc_next,
    output logic [DW-1:0] be_wdata,
    output logic [DW-1:0] rd_value
);
    logic [2:0]    nb, ab, shb;
    logic [1:0]    kk;
    logic [5:0]    sh, nbits, pshift;
    logic [DW-1:0] nmask, amask, native, merged, piece;
    logic          narrow;

    always_comb begin
        nb     = 3'd1 << nlog;
        ab     = 3'd1 << alog;
        kk     = koff & 2'(nb - 3'd1);
        shb    = nb - ab - {1'b0, kk};
        sh     = {shb, 3'b000};
        nbits  = 6'd8 << nlog;
        nmask  = lane_mask(nlog);
        amask  = lane_mask(alog);
        narrow = (alog < nlog);
        native = be_rdata & nmask;

        acc_next = split ? ((acc << nbits) | native) : native;
        rd_value = narrow ? ((acc >> sh) & amask) : acc;

        merged = (acc & ~(amask << sh)) | ((wdata & amask) << sh);
        pshift = 6'(32'(last - idx) << (32'(nlog) + 32'd3));
        piece  = (wdata >> pshift) & nmask;

        if (wback)      be_wdata = merged;
        else if (split) be_wdata = piece;
        else            be_wdata = wdata & nmask;
    end

endmodule

// File: rtl/rwa_adapter.sv
module rwa_adapter
    import rwa_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int LIMIT  = 512,
    parameter logic [2*(LIMIT/4)-1:0] MAP = rwa_pkg::default_map()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              be_valid,
    output logic              be_write,
    output logic [1:0]        be_size,
    output logic [9:0]        be_addr,
    output logic [31:0]       be_wdata,
    input  logic [31:0]       be_rdata
);
    localparam int NSLOT = LIMIT / 4;

    logic             c_bad;
    logic [1:0]       c_nlog;
    logic [OFF_W-1:0] c_off;

    logic             q_wr, q_err;
    logic [1:0]       q_alog, q_nlog;
    logic [OFF_W-1:0] q_off;
    logic [DW-1:0]    q_wdata, acc, acc_next, rd_value;

    seq_st_t          st;
    logic [1:0]       idx, last;
    logic             be_go, wback, done, split, rmw, accept;
    logic [OFF_W-1:0] nb_mask;

    rwa_classify #(.BUS_AW(BUS_AW), .LIMIT(LIMIT), .NSLOT(NSLOT), .MAP(MAP)) u_cls (
        .addr (req_addr),
        .size (req_size),
        .bad  (c_bad),
        .nlog (c_nlog),
        .off  (c_off)
    );

    always_comb begin
        split  = (q_alog > q_nlog);
        rmw    = q_wr && (q_alog < q_nlog);
        last   = !split ? 2'd0 : ((q_alog - q_nlog) == 2'd1 ? 2'd1 : 2'd3);
        accept = (st == ST_IDLE) && req_valid;
    end

    rwa_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bad       (c_bad),
        .rmw       (rmw),
        .last      (last),
        .st        (st),
        .idx       (idx),
        .be_go     (be_go),
        .wback     (wback),
        .done      (done)
    );

    rwa_lanes u_lanes (
        .alog     (q_alog),
        .nlog     (q_nlog),
        .koff     (q_off[1:0]),
        .idx      (idx),
        .last     (last),
        .split    (split),
        .wback    (wback),
        .acc      (acc),
        .wdata    (q_wdata),
        .be_rdata (be_rdata),
        .acc_next (acc_next),
        .be_wdata (be_wdata),
        .rd_value (rd_value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_wr    <= 1'b0;
            q_err   <= 1'b0;
            q_alog  <= 2'd0;
            q_nlog  <= 2'd0;
            q_off   <= '0;
            q_wdata <= '0;
            acc     <= '0;
        end else if (accept) begin
            q_wr    <= req_write;
            q_err   <= c_bad;
            q_alog  <= req_size;
            q_nlog  <= c_nlog;
            q_off   <= c_off;
            q_wdata <= req_wdata;
            acc     <= '0;
        end else if (be_go && !be_write) begin
            acc <= acc_next;
        end
    end

    always_comb begin
        nb_mask   = OFF_W'((32'd1 << q_nlog) - 32'd1);
        be_valid  = be_go;
        be_write  = wback || (be_go && q_wr && !rmw);
        be_size   = q_nlog;
        be_addr   = split ? (q_off + (OFF_W'(idx) << q_nlog)) : (q_off & ~nb_mask);
        req_ready = done;
        rsp_err   = done && q_err;
        rsp_rdata = (done && !q_wr && !q_err) ? rd_value : '0;
    end

endmodule

// File: rtl/rwa_adapter_chk.sv
module rwa_adapter_chk #(
    parameter int LIMIT = 512,
    parameter logic [2*(LIMIT/4)-1:0] MAP = '0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_err,
    input logic       be_valid,
    input logic       be_write,
    input logic [1:0] be_size,
    input logic [9:0] be_addr
);
    localparam int SLOT_W = $clog2(LIMIT / 4);

    logic [1:0] code_at;
    logic [9:0] algn;
    always_comb begin
        code_at = MAP[{be_addr[SLOT_W+1:2], 1'b0} +: 2];
        algn    = 10'((32'd1 << be_size) - 32'd1);
    end

    // R8: completion is a single-cycle pulse
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R8: a good response follows the last backend access directly
    p_ready_after_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !rsp_err) |-> $past(be_valid));

    // R2: an error response is preceded by no backend access
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && rsp_err) |-> !$past(be_valid));

    // R7: backend size matches the slot native width
    p_native_r7: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (code_at != 2'd0 && be_size == code_at - 2'd1));

    // R7: backend address aligned and inside the window
    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> ((be_addr & algn) == 10'd0 && 32'(be_addr) < LIMIT));

    // R5: a write right after a read targets the same register
    p_wback_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_write && $past(be_valid && !be_write))
            |-> (be_addr == $past(be_addr) && be_size == $past(be_size)));

endmodule

bind rwa_adapter rwa_adapter_chk #(.LIMIT(LIMIT), .MAP(MAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_err   (rsp_err),
    .be_valid  (be_valid),
    .be_write  (be_write),
    .be_size   (be_size),
    .be_addr   (be_addr)
);

// File: tb/test_rwa_adapter.sv
`timescale 1ns/1ps
module test_rwa_adapter;

    localparam int HALF = 4;   // 125 MHz
    localparam int AW   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_err, be_valid, be_write;
    logic [31:0] rsp_rdata, be_wdata, be_rdata;
    logic [1:0]  be_size;
    logic [9:0]  be_addr;

    int checks = 0, errors = 0;
    int be_cnt = 0, native_bad = 0;
    logic [7:0] mem    [0:511];
    logic [7:0] shadow [0:511];

    always #HALF clk = ~clk;

    rwa_adapter #(.BUS_AW(AW)) i_rwa_adapter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .be_valid(be_valid), .be_write(be_write), .be_size(be_size),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata)
    );

    // R9 default map, in bytes (0 = empty)
    function automatic int bw(input int off);
        if (off < 'h40)       return 1;
        else if (off < 'h80)  return 2;
        else if (off < 'hC0)  return 4;
        else if (off < 'h100) return 0;
        else if (off < 'h200) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] init_byte(input int i);
        return 8'(i * 29 + 7);
    endfunction

    // backend register file model, big-endian bytes
    always_comb begin
        int a;
        a = int'(be_addr[8:0]);
        case (be_size)
            2'd0:    be_rdata = {24'd0, mem[a]};
            2'd1:    be_rdata = {16'd0, mem[a], mem[(a+1)%512]};
            default: be_rdata = {mem[a], mem[(a+1)%512], mem[(a+2)%512], mem[(a+3)%512]};
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= init_byte(i);
        end else if (be_valid) begin
            int a, n;
            a = int'(be_addr[8:0]);
            n = 1 << be_size;
            be_cnt <= be_cnt + 1;
            if (n != bw(int'(be_addr)) || (a % n) != 0) native_bad <= native_bad + 1;
            if (be_write)
                for (int i = 0; i < n; i++)
                    mem[(a+i)%512] <= 8'(be_wdata >> (8*(n-1-i)));
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er,
                          output int nbe, output int lat);
        int b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        b0 = be_cnt; lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (req_ready || lat > 40) break;
        end
        rd = rsp_rdata; er = rsp_err; nbe = be_cnt - b0;
        req_valid = 1'b0;
    endtask

    function automatic logic exp_err(input logic [1:0] sz, input logic [AW-1:0] addr);
        int off;
        off = int'(addr[9:0]);
        if (off >= 'h200 || sz == 2'd3) return 1'b1;
        if ((off % (1 << sz)) != 0) return 1'b1;
        return (bw(off) == 0);
    endfunction

    // full bench-side check of one access against the shadow model
    task automatic run(input logic wr, input logic [1:0] sz, input logic [AW-1:0] addr, input logic [31:0] wd);
        logic [31:0] rd, exp_rd;
        logic er, ee;
        int nbe, lat, off, a, n, en;
        string tg;
        off = int'(addr[9:0]);
        ee  = exp_err(sz, addr);
        access(wr, sz, addr, wd, rd, er, nbe, lat);
        check("R2", "err", 32'(er), 32'(ee));
        check("R8", "latency", 32'(lat), 32'(nbe + 1));
        if (ee) begin
            check("R2", "no backend", 32'(nbe), 32'd0);
            check("R2", "rdata zero", rd, 32'd0);
            return;
        end
        a = 1 << sz; n = bw(off);
        if (a == n)     begin tg = "R3"; en = 1;  end
        else if (a > n) begin tg = "R6"; en = a / n; end
        else if (wr)    begin tg = "R5"; en = 2;  end
        else            begin tg = "R4"; en = 1;  end
        check(tg, "backend count", 32'(nbe), 32'(en));
        if (wr) begin
            for (int i = 0; i < a; i++) shadow[off+i] = 8'(wd >> (8*(a-1-i)));
        end else begin
            exp_rd = '0;
            for (int i = 0; i < a; i++) exp_rd = (exp_rd << 8) | {24'd0, shadow[off+i]};
            check(tg, "rdata", rd, exp_rd);
        end
    endtask

    initial begin
        #(2*HALF*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        for (int i = 0; i < 512; i++) shadow[i] = init_byte(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "reset ready", 32'(req_ready), 32'd0);
        check("R8", "reset be_valid", 32'(be_valid), 32'd0);
        rst_n = 1'b1;

        // R9 boundaries of the default map: word reads count native pieces
        run(1'b0, 2'd2, 16'h003C, 32'd0);   // byte slots, 4 pieces
        run(1'b0, 2'd2, 16'h0040, 32'd0);   // halfword slots, 2 pieces
        run(1'b0, 2'd2, 16'h0080, 32'd0);   // word slot, 1 access
        run(1'b0, 2'd2, 16'h00C0, 32'd0);   // empty slot, error
        run(1'b0, 2'd2, 16'h0100, 32'd0);   // byte slots again
        // R2 corner cases
        run(1'b0, 2'd0, 16'h0200, 32'd0);
        run(1'b1, 2'd1, 16'h03FE, 32'h1234);
        run(1'b0, 2'd3, 16'h0080, 32'd0);
        run(1'b0, 2'd2, 16'h0082, 32'd0);
        run(1'b1, 2'd1, 16'h0041, 32'hBEEF);
        // R5 narrow writes into a word register, then whole read-back
        run(1'b1, 2'd0, 16'h0085, 32'h0000_00A5);
        run(1'b1, 2'd1, 16'h0086, 32'h0000_C3D2);
        run(1'b0, 2'd2, 16'h0084, 32'd0);
        // R4 byte read of a halfword register, both lanes
        run(1'b0, 2'd0, 16'h0050, 32'd0);
        run(1'b0, 2'd0, 16'h0051, 32'd0);
        // R6 word write to byte registers, read back bytewise
        run(1'b1, 2'd2, 16'h0010, 32'h1122_3344);
        run(1'b0, 2'd0, 16'h0010, 32'd0);
        run(1'b0, 2'd0, 16'h0013, 32'd0);
        // R1 upper address bits ignored
        run(1'b1, 2'd0, 16'hFC14, 32'h0000_005A);
        run(1'b0, 2'd0, 16'h0014, 32'd0);
        run(1'b0, 2'd1, 16'hA854, 32'd0);

        for (int it = 0; it < 600; it++) begin
            logic [1:0] sz;
            logic [9:0] off;
            logic [5:0] hi;
            int r;
            r  = int'($urandom % 100);
            sz = (r < 3) ? 2'd3 : 2'($urandom % 3);
            off = 10'($urandom % 512);
            if (r > 8 && sz != 2'd3) off = off & ~10'((1 << sz) - 1);
            if (r > 95) off = off | 10'h200;
            hi = 6'($urandom);
            run(1'($urandom % 2), sz, {hi, off}, $urandom);
        end

        check("R7", "native/aligned violations", 32'(native_bad), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule